// File: doc/BRIEF.md
# Irregularly Clocked Keystream Generator

This block produces a keystream from three data shift registers (19, 22 and 23 bits) whose stepping is decided by a separate 17-bit control register. A one-cycle `start` pulse latches a 64-bit key and a 22-bit frame number. The block then runs a fixed setup sequence: key injection, frame injection, a mixing run and one priming cycle. After that it streams 228 keystream bits, one per cycle. The bits form two 114-bit directional blocks.

The control register steps on every active clock. Three of its bits vote by majority, and each data register steps only when its own control bit agrees with the vote. Each output bit is the XOR of the three register top bits and three small majority functions, some of whose inputs are inverted. The bit is issued one step late, so each emitted bit reflects the register state before that step's clock. Beside the bit stream, a packer gathers each block into bytes, first bit in the MSB. The fifteenth byte of each block is padded with zeros.

Top module: `irreg_keystream_gen`

## Requirements
- R1: The data registers A (19 bits), B (22 bits) and C (23 bits) and the control register D (17 bits) all step the same way: shift left by one, drop the bit above the width, and set bit 0 to the XOR of the tap bits taken before the shift. The taps are A{18,17,16,13}, B{21,20}, C{22,21,20,7} and D{16,11}.
- R2: A `start` pulse seen while idle clears all four registers. On each of the next 64 cycles, all four registers step and key bit i is XORed into bit 0 of each. Bit i is `key[i]`, starting with i=0, so key byte 0 occupies `key[7:0]`.
- R3: The next 22 cycles inject `frame[0]` through `frame[21]` in the same way. On the last of these cycles, A[15], B[16], C[18] and D[10] are forced to 1 after the shift and before the XOR.
- R4: In the mixing and streaming phases, D steps every cycle. Let m be the majority of D[10], D[3] and D[7]. A steps only when D[10]==m, B only when D[3]==m, and C only when D[7]==m. A register that does not step holds its value.
- R5: `busy` is high for exactly 187 cycles, starting the cycle after `start` is sampled: 64 key cycles, 22 frame cycles, 100 mixing cycles and 1 priming cycle with no register step.
- R6: The raw output is A[18]^B[21]^C[22]^maj(A[15],~A[14],A[12])^maj(~B[16],B[13],B[9])^maj(C[18],C[16],~C[13]).
- R7: `ks_valid` rises one cycle after `busy` falls and stays high for 228 consecutive cycles. Output bit k carries the raw output of the register state just before the k-th streaming clock.
- R8: `ks_dir` is 0 for the first 114 keystream bits and 1 for the following 114.
- R9: `byte_valid` pulses alongside every 8th bit of a block and alongside its 114th bit. Bits fill `byte_data` from bit 7 downward. The 15th byte carries the last two bits in [7:6] and zeros in [5:0].
- R10: With `key`=64'hFFFFFFFFFFFFFC00 and `frame`=22'h21, the first block begins with bytes F4 51 2C AC 13 59 and the second block begins with 48 00 D4 32 8E 16.
- R11: A `start` pulse during setup or streaming has no effect on any output.
- R12: While in reset, and after reset until the first `start`, `busy`, `ks_valid` and `byte_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch key and frame and begin setup (only honoured while idle) |
| key | input | 64 | Key, setup bit i is key[i] |
| frame | input | 22 | Frame number, injected LSB first |
| busy | output | 1 | Setup in progress |
| ks_valid | output | 1 | Keystream bit present on ks_bit |
| ks_bit | output | 1 | Keystream bit |
| ks_dir | output | 1 | Block indicator, 0 for the first 114 bits and 1 for the second |
| byte_valid | output | 1 | Packed byte present on byte_data |
| byte_data | output | 8 | Packed keystream byte, MSB first |

## Verification
The published vector is the sharpest corner. A swapped key bit order, a missing forced bit on the last frame cycle or a misplaced output delay would leave every later byte wrong. The bench compares every cycle against an independent integer model, so an off-by-one in a phase length shows up as `busy` or `ks_valid` moving a cycle early or late. The 15th byte of each block is checked for its zero padding, since a packer that ignored the short tail would shift old bits into the low positions. Stray `start` pulses are sent during both setup and streaming: a design that restarted would break the stream that follows.

// File: rtl/kgen_pkg.sv
package kgen_pkg;
  localparam int A_W = 19;
  localparam int B_W = 22;
  localparam int C_W = 23;
  localparam int D_W = 17;

  localparam logic [A_W-1:0] A_TAPS = 19'h72000;
  localparam logic [B_W-1:0] B_TAPS = 22'h300000;
  localparam logic [C_W-1:0] C_TAPS = 23'h700080;
  localparam logic [D_W-1:0] D_TAPS = 17'h10800;

  localparam int A_FORCE = 15;
  localparam int B_FORCE = 16;
  localparam int C_FORCE = 18;
  localparam int D_FORCE = 10;

  // control register bits steering A, B and C
  localparam int CTL_A = 10;
  localparam int CTL_B = 3;
  localparam int CTL_C = 7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_KEY, PH_FRAME, PH_MIX, PH_PRIME, PH_STREAM
  } phase_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/kgen_shift_stage.sv
module kgen_shift_stage #(
  parameter int           W         = 19,
  parameter logic [W-1:0] TAPS      = '0,
  parameter int           FORCE_POS = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic         force_one,
  input  logic         inj,
  output logic [W-1:0] q
);
  logic [W-1:0] shifted;
  logic [W-1:0] q_n;

  always_comb begin
    shifted = {q[W-2:0], ^(q & TAPS)};
    if (force_one) shifted[FORCE_POS] = 1'b1;
    shifted[0] = shifted[0] ^ inj;
    if (clr)      q_n = '0;
    else if (adv) q_n = shifted;
    else          q_n = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/kgen_seq.sv
module kgen_seq
  import kgen_pkg::*;
#(
  parameter int KEY_BITS   = 64,
  parameter int FRAME_BITS = 22,
  parameter int MIX_CLOCKS = 100,
  parameter int BLOCK_BITS = 114,
  localparam int MAXC  = (KEY_BITS > FRAME_BITS) ?
                         ((KEY_BITS > MIX_CLOCKS) ? KEY_BITS : MIX_CLOCKS) :
                         ((FRAME_BITS > MIX_CLOCKS) ? FRAME_BITS : MIX_CLOCKS),
  localparam int CNT_W = $clog2(MAXC),
  localparam int POS_W = $clog2(BLOCK_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [KEY_BITS-1:0]   key,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  clr,
  output logic                  load,
  output logic                  run,
  output logic                  inj,
  output logic                  force_one,
  output logic                  step,
  output logic [POS_W-1:0]      pos,
  output logic                  dir,
  output logic                  busy
);
  phase_e                ph, ph_n;
  logic [CNT_W-1:0]      cnt, cnt_n;
  logic [KEY_BITS-1:0]   key_sr, key_sr_n;
  logic [FRAME_BITS-1:0] frm_sr, frm_sr_n;
  logic [POS_W-1:0]      pos_n;
  logic                  dir_n;

  always_comb begin
    ph_n      = ph;
    cnt_n     = cnt;
    key_sr_n  = key_sr;
    frm_sr_n  = frm_sr;
    pos_n     = pos;
    dir_n     = dir;
    inj       = 1'b0;
    force_one = 1'b0;
    clr       = 1'b0;
    unique case (ph)
      PH_IDLE: if (start) begin
        ph_n     = PH_KEY;
        cnt_n    = '0;
        key_sr_n = key;
        frm_sr_n = frame;
        clr      = 1'b1;
      end
      PH_KEY: begin
        inj      = key_sr[0];
        key_sr_n = key_sr >> 1;
        cnt_n    = cnt + 1'b1;
        if (cnt == CNT_W'(KEY_BITS - 1)) begin
          ph_n  = PH_FRAME;
          cnt_n = '0;
        end
      end
      PH_FRAME: begin
        inj      = frm_sr[0];
        frm_sr_n = frm_sr >> 1;
        cnt_n    = cnt + 1'b1;
        if (cnt == CNT_W'(FRAME_BITS - 1)) begin
          force_one = 1'b1;
          ph_n      = PH_MIX;
          cnt_n     = '0;
        end
      end
      PH_MIX: begin
        cnt_n = cnt + 1'b1;
        if (cnt == CNT_W'(MIX_CLOCKS - 1)) begin
          ph_n  = PH_PRIME;
          cnt_n = '0;
        end
      end
      PH_PRIME: begin
        ph_n  = PH_STREAM;
        pos_n = '0;
        dir_n = 1'b0;
      end
      PH_STREAM: begin
        pos_n = pos + 1'b1;
        if (pos == POS_W'(BLOCK_BITS - 1)) begin
          pos_n = '0;
          if (dir) ph_n = PH_IDLE;
          else     dir_n = 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  assign load = (ph == PH_KEY) || (ph == PH_FRAME);
  assign run  = (ph == PH_MIX) || (ph == PH_STREAM);
  assign step = (ph == PH_STREAM);
  assign busy = load || (ph == PH_MIX) || (ph == PH_PRIME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      key_sr <= '0;
      frm_sr <= '0;
      pos    <= '0;
      dir    <= 1'b0;
    end else begin
      ph     <= ph_n;
      cnt    <= cnt_n;
      key_sr <= key_sr_n;
      frm_sr <= frm_sr_n;
      pos    <= pos_n;
      dir    <= dir_n;
    end
  end
endmodule

// File: rtl/kgen_output.sv
module kgen_output
  import kgen_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           dir,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic [C_W-1:0] c,
  output logic           raw,
  output logic           ks_valid,
  output logic           ks_bit,
  output logic           ks_dir
);
  logic bit_n, dir_n;

  always_comb begin
    raw = a[A_W-1] ^ b[B_W-1] ^ c[C_W-1]
        ^ maj3(a[15], ~a[14], a[12])
        ^ maj3(~b[16], b[13], b[9])
        ^ maj3(c[18], c[16], ~c[13]);
    bit_n = step ? raw : ks_bit;
    dir_n = step ? dir : ks_dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks_valid <= 1'b0;
      ks_bit   <= 1'b0;
      ks_dir   <= 1'b0;
    end else begin
      ks_valid <= step;
      ks_bit   <= bit_n;
      ks_dir   <= dir_n;
    end
  end
endmodule

// File: rtl/kgen_packer.sv
module kgen_packer #(
  parameter int BLOCK_BITS = 114,
  localparam int POS_W = $clog2(BLOCK_BITS),
  localparam int TAIL  = BLOCK_BITS % 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             bit_in,
  input  logic [POS_W-1:0] pos,
  output logic             byte_valid,
  output logic [7:0]       byte_data
);
  logic [7:0] acc, acc_n, data_n;
  logic       emit;
  logic       last;

  always_comb begin
    acc_n  = {acc[6:0], bit_in};
    last   = (pos == POS_W'(BLOCK_BITS - 1));
    emit   = step && ((pos[2:0] == 3'd7) || last);
    data_n = acc_n;
    if (TAIL != 0 && last) data_n = acc_n << (8 - TAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= emit;
      if (step) acc <= acc_n;
      if (emit) byte_data <= data_n;
    end
  end
endmodule

// File: rtl/irreg_keystream_gen.sv
module irreg_keystream_gen
  import kgen_pkg::*;
#(
  parameter int KEY_BITS   = 64,
  parameter int FRAME_BITS = 22,
  parameter int MIX_CLOCKS = 100,
  parameter int BLOCK_BITS = 114,
  localparam int POS_W = $clog2(BLOCK_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [KEY_BITS-1:0]   key,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  busy,
  output logic                  ks_valid,
  output logic                  ks_bit,
  output logic                  ks_dir,
  output logic                  byte_valid,
  output logic [7:0]            byte_data
);
  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic             clr_s, load_s, run_s, inj_s, force_s, step_s, dir_s, raw_s;
  logic [POS_W-1:0] pos_s;
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic [C_W-1:0]   c_q;
  logic [D_W-1:0]   d_q;
  logic             vote, adv_a, adv_b, adv_c, adv_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  kgen_seq #(
    .KEY_BITS(KEY_BITS), .FRAME_BITS(FRAME_BITS),
    .MIX_CLOCKS(MIX_CLOCKS), .BLOCK_BITS(BLOCK_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .key(key), .frame(frame),
    .clr(clr_s), .load(load_s), .run(run_s), .inj(inj_s),
    .force_one(force_s), .step(step_s), .pos(pos_s), .dir(dir_s),
    .busy(busy)
  );

  always_comb begin
    vote  = maj3(d_q[CTL_A], d_q[CTL_B], d_q[CTL_C]);
    adv_a = load_s || (run_s && (d_q[CTL_A] == vote));
    adv_b = load_s || (run_s && (d_q[CTL_B] == vote));
    adv_c = load_s || (run_s && (d_q[CTL_C] == vote));
    adv_d = load_s || run_s;
  end

  kgen_shift_stage #(.W(A_W), .TAPS(A_TAPS), .FORCE_POS(A_FORCE)) u_a (
    .clk(clk), .rst_n(rst_i_n), .clr(clr_s), .adv(adv_a),
    .force_one(force_s), .inj(inj_s), .q(a_q));
  kgen_shift_stage #(.W(B_W), .TAPS(B_TAPS), .FORCE_POS(B_FORCE)) u_b (
    .clk(clk), .rst_n(rst_i_n), .clr(clr_s), .adv(adv_b),
    .force_one(force_s), .inj(inj_s), .q(b_q));
  kgen_shift_stage #(.W(C_W), .TAPS(C_TAPS), .FORCE_POS(C_FORCE)) u_c (
    .clk(clk), .rst_n(rst_i_n), .clr(clr_s), .adv(adv_c),
    .force_one(force_s), .inj(inj_s), .q(c_q));
  kgen_shift_stage #(.W(D_W), .TAPS(D_TAPS), .FORCE_POS(D_FORCE)) u_d (
    .clk(clk), .rst_n(rst_i_n), .clr(clr_s), .adv(adv_d),
    .force_one(force_s), .inj(inj_s), .q(d_q));

  kgen_output u_out (
    .clk(clk), .rst_n(rst_i_n), .step(step_s), .dir(dir_s),
    .a(a_q), .b(b_q), .c(c_q), .raw(raw_s),
    .ks_valid(ks_valid), .ks_bit(ks_bit), .ks_dir(ks_dir));

  kgen_packer #(.BLOCK_BITS(BLOCK_BITS)) u_pack (
    .clk(clk), .rst_n(rst_i_n), .step(step_s), .bit_in(raw_s),
    .pos(pos_s), .byte_valid(byte_valid), .byte_data(byte_data));
endmodule

// File: rtl/irreg_keystream_gen_chk.sv
module irreg_keystream_gen_chk #(
  parameter int BLOCK_BITS = 114,
  localparam int PAD   = (BLOCK_BITS % 8 == 0) ? 0 : 8 - (BLOCK_BITS % 8),
  localparam int CNT_W = $clog2(BLOCK_BITS)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ks_valid,
  input logic        ks_dir,
  input logic        byte_valid,
  input logic [7:0]  byte_data,
  input logic [16:0] ctl_q,
  input logic [18:0] a_q,
  input logic        run
);
  logic [CNT_W-1:0] vcnt;
  logic             vote;

  assign vote = (ctl_q[10] & ctl_q[3]) | (ctl_q[10] & ctl_q[7]) | (ctl_q[3] & ctl_q[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcnt <= '0;
    else if (ks_valid)
      vcnt <= (vcnt == CNT_W'(BLOCK_BITS - 1)) ? '0 : vcnt + 1'b1;
  end

  assert_not_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ks_valid));

  assert_stream_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> $rose(ks_valid));

  assert_first_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ks_valid) |-> !ks_dir);

  assert_dir_one_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && $past(ks_valid) && (ks_dir != $past(ks_dir))) |-> ks_dir);

  assert_hold_when_outvoted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (ctl_q[10] != vote)) |=> $stable(a_q));

  assert_byte_with_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> ks_valid);

  assert_tail_padding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && vcnt == CNT_W'(BLOCK_BITS - 1)) |-> ((byte_data & 8'((1 << PAD) - 1)) == 8'h00));
endmodule

bind irreg_keystream_gen irreg_keystream_gen_chk #(.BLOCK_BITS(BLOCK_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ks_valid(ks_valid), .ks_dir(ks_dir),
  .byte_valid(byte_valid), .byte_data(byte_data), .ctl_q(d_q), .a_q(a_q),
  .run(run_s));

// File: tb/irreg_keystream_gen_test.sv
module irreg_keystream_gen_test;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [63:0] key;
  logic [21:0] frame;
  logic        busy, ks_valid, ks_bit, ks_dir, byte_valid;
  logic [7:0]  byte_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit         exp_bits [0:227];
  logic [7:0] exp_bytes [0:1][0:14];
  logic [7:0] got_bytes [0:1][0:14];

  irreg_keystream_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .frame(frame),
    .busy(busy), .ks_valid(ks_valid), .ks_bit(ks_bit), .ks_dir(ks_dir),
    .byte_valid(byte_valid), .byte_data(byte_data));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // one register step per R1
  function automatic int unsigned lstep(input int unsigned r, input int w, input int unsigned taps);
    int unsigned m = (32'd1 << w) - 1;
    return ((r << 1) & m) | (32'($countones(r & taps)) & 32'd1);
  endfunction

  function automatic int unsigned bt(input int unsigned r, input int n);
    return (r >> n) & 32'd1;
  endfunction

  function automatic int unsigned vote3(input int unsigned x, input int unsigned y, input int unsigned z);
    return (x + y + z >= 2) ? 32'd1 : 32'd0;
  endfunction

  task automatic build_ref(input logic [63:0] k, input logic [21:0] f);
    int unsigned a = 0, b = 0, c = 0, d = 0, m, raw, kb;
    for (int i = 0; i < 86; i++) begin
      a = lstep(a, 19, 32'h72000);
      b = lstep(b, 22, 32'h300000);
      c = lstep(c, 23, 32'h700080);
      d = lstep(d, 17, 32'h10800);
      if (i == 85) begin  // R3 forced bits
        a |= 32'd1 << 15; b |= 32'd1 << 16; c |= 32'd1 << 18; d |= 32'd1 << 10;
      end
      kb = (i < 64) ? 32'(k[i]) : 32'(f[i-64]);
      a ^= kb; b ^= kb; c ^= kb; d ^= kb;
    end
    for (int i = 0; i < 100 + 228; i++) begin
      if (i >= 100) begin
        raw = bt(a,18) ^ bt(b,21) ^ bt(c,22)
            ^ vote3(bt(a,15), 1 - bt(a,14), bt(a,12))
            ^ vote3(1 - bt(b,16), bt(b,13), bt(b,9))
            ^ vote3(bt(c,18), bt(c,16), 1 - bt(c,13));
        exp_bits[i-100] = raw[0];
      end
      m = vote3(bt(d,10), bt(d,3), bt(d,7));
      if (bt(d,10) == m) a = lstep(a, 19, 32'h72000);
      if (bt(d,3)  == m) b = lstep(b, 22, 32'h300000);
      if (bt(d,7)  == m) c = lstep(c, 23, 32'h700080);
      d = lstep(d, 17, 32'h10800);
    end
    for (int blk = 0; blk < 2; blk++)
      for (int j = 0; j < 15; j++) begin
        exp_bytes[blk][j] = 8'h00;
        for (int t = 0; t < 8; t++)
          if (8*j + t < 114) exp_bytes[blk][j][7-t] = exp_bits[114*blk + 8*j + t];
      end
  endtask

  task automatic session(input logic [63:0] k, input logic [21:0] f, input bit stray);
    int s, p;
    build_ref(k, f);
    @(negedge clk);
    key = k; frame = f; start = 1'b1;
    for (int e = 0; e < 420; e++) begin
      @(negedge clk);
      chk(busy == (e <= 186), "R5 busy", 64'(busy), 64'(e <= 186));
      chk(ks_valid == (e >= 188 && e <= 415), "R7 ks_valid", 64'(ks_valid), 64'(e >= 188 && e <= 415));
      if (e >= 188 && e <= 415) begin
        s = e - 188; p = s % 114;
        chk(ks_bit == exp_bits[s], "R6 ks_bit", 64'(ks_bit), 64'(exp_bits[s]));
        chk(ks_dir == (s >= 114), "R8 ks_dir", 64'(ks_dir), 64'(s >= 114));
        chk(byte_valid == ((p % 8 == 7) || p == 113), "R9 byte_valid",
            64'(byte_valid), 64'((p % 8 == 7) || p == 113));
        if (byte_valid) begin
          chk(byte_data == exp_bytes[s/114][p/8], "R9 byte_data",
              64'(byte_data), 64'(exp_bytes[s/114][p/8]));
          got_bytes[s/114][p/8] = byte_data;
        end
      end else begin
        chk(!byte_valid, "R9 byte_valid idle", 64'(byte_valid), 64'd0);
      end
      // R11: stray start pulses with another key during setup and streaming
      start = stray && (e == 40 || e == 250);
      if (start) begin key = ~k; frame = ~f; end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; key = '0; frame = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !ks_valid && !byte_valid, "R12 in reset", {busy, ks_valid, byte_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !ks_valid && !byte_valid, "R12 after reset", {busy, ks_valid, byte_valid}, 64'd0);

    // R2, R3, R10: published vector
    session(64'hFFFF_FFFF_FFFF_FC00, 22'h21, 1'b0);
    begin
      logic [7:0] v0 [0:5] = '{8'hF4, 8'h51, 8'h2C, 8'hAC, 8'h13, 8'h59};
      logic [7:0] v1 [0:5] = '{8'h48, 8'h00, 8'hD4, 8'h32, 8'h8E, 8'h16};
      for (int j = 0; j < 6; j++) begin
        chk(got_bytes[0][j] == v0[j], "R10 first block", 64'(got_bytes[0][j]), 64'(v0[j]));
        chk(got_bytes[1][j] == v1[j], "R10 second block", 64'(got_bytes[1][j]), 64'(v1[j]));
      end
      chk(got_bytes[0][14][5:0] == 6'd0, "R9 tail pad", 64'(got_bytes[0][14]), 64'(exp_bytes[0][14]));
    end

    // R4, R11: another key, with stray start pulses
    session(64'h0123_4567_89AB_CDEF, 22'h3A5C1, 1'b1);
    // R1: all-zero key and frame
    session(64'h0, 22'h0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule